// File: doc/BRIEF.md
# Exception stack frame sequencer

This block carries out the memory side effects of four control-flow operations: a software trap, a return from subroutine, a push of a computed address, and an unlink of a frame pointer. It owns the stack pointer. For each operation it issues one memory access at a time on a simple request/ready interface, and it waits for ready on every access. When the operation is complete it reports the new program counter, the new stack pointer, the supervisor bit and, for an unlink, the reloaded address register.

A start pulse carries the operation code and every operand the sequence may need: trap number, vector base, next PC, status register and an address-register value. All of these are captured when the request is accepted. A trap pushes a three-part frame: the return PC, the status word, and a format/offset word that identifies the vector. It then reads the handler address from the vector table. Instruction fetch, privilege checks and the rest of the pipeline sit outside the block.

Top module: `frame_seq`

## Requirements
- R1: After reset `sp_out` equals parameter `SP_RESET` (default 0x400), `pc_out`, `areg_out` and `s_bit` are 0, and `busy`, `done` and `mem_req` are low.
- R2: With `op` = 2'b00 (trap) the block makes three writes in this order. The first is a long write of `next_pc` at SP-4. The second is a word write at SP-6 of `sr_in` with bit 13 (supervisor) forced to 1. The third is a word write at SP-8 of the format/offset word. The final `sp_out` is the starting SP minus 8.
- R3: The format/offset word has the format code parameter `FMT_CODE` (default 4) in bits 15:12, zeros in bits 11:10, and (32 + trap number) × 4 in bits 9:0.
- R4: After the frame, a trap makes a long read at `vbr` + 0x80 + 4 × trap number. `pc_out` becomes the read data and `s_bit` becomes 1.
- R5: With `op` = 2'b01 (return) the block makes one long read at SP. `pc_out` becomes the read data and `sp_out` becomes SP + 4.
- R6: With `op` = 2'b10 (push address) the block makes one long write of `areg_in` at SP-4, and `sp_out` becomes SP-4.
- R7: With `op` = 2'b11 (unlink) SP is first loaded from `areg_in`. The block then makes one long read at that address, `areg_out` becomes the read data, and `sp_out` becomes `areg_in` + 4.
- R8: While `mem_req` is high and `mem_ready` is low, the address, write data, write enable and size stay unchanged. A long access has `mem_long` = 1. A word write places its data in `mem_wdata[15:0]` and sets the upper bits to zero.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the final access. `busy` is low in that cycle.
- R10: A `start` received while `busy` is high is ignored. It causes no extra access and no change to SP or PC.
- R11: For non-trap operations `pc_out` equals the captured `next_pc` (except for a return) and `s_bit` equals bit 13 of the captured `sr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op | input | 2 | Operation: 0 trap, 1 return, 2 push address, 3 unlink |
| trap_num | input | 4 | Trap number n |
| vbr | input | 32 | Vector table base |
| next_pc | input | 32 | PC of the following instruction |
| sr_in | input | 16 | Status register value |
| areg_in | input | 32 | Address-register value or computed address |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes on this cycle |
| pc_out | output | 32 | Resulting PC |
| sp_out | output | 32 | Current stack pointer |
| areg_out | output | 32 | Reloaded address register (unlink) |
| s_bit | output | 1 | Supervisor bit after the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in the sequencer shows up on the memory interface on the very next access. The fault may be a skipped frame slot, a wrong SP decrement or an access that starts before ready. It then appears as a wrong address, a wrong size or write flag, or an extra or missing handshake, within one access time. A corrupted stack pointer surfaces on `sp_out` as soon as `done` pulses, and it shows again in the addresses of the next operation. A start that slips through while busy shows up as a fifth access or an SP change before the current `done`.

// File: rtl/frame_seq_pkg.sv
// Shared types for the stack frame sequencer.
// Assumes: four operations encoded on two bits; one state per memory access.
package frame_seq_pkg;

    typedef enum logic [1:0] {
        OP_TRAP = 2'd0,
        OP_RTS  = 2'd1,
        OP_PEA  = 2'd2,
        OP_UNLK = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_PUSH_FMT,
        ST_FETCH_VEC,
        ST_POP_PC,
        ST_PUSH_EA,
        ST_POP_AREG
    } seq_state_e;

    localparam int SR_SUPER_BIT = 13;
    localparam int SR_W         = 16;
    localparam int VEC_FIRST    = 32;

endpackage

// File: rtl/frame_seq_fmt.sv
// Format/offset word and vector-table address generator.
// Computes the vector number 32+n, its byte offset (x4), the frame word
// {format, 00, offset} and the handler slot address vbr + offset.
// Assumes the trap number and base are held stable by the caller.
module frame_seq_fmt
    import frame_seq_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         TRAP_W   = 4,
    parameter logic [3:0] FMT_CODE = 4'h4
) (
    input  logic [TRAP_W-1:0] trap_num,
    input  logic [ADDR_W-1:0] vbr,
    output logic [SR_W-1:0]   fmt_word,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int OFS_W = 10;
    localparam int VN_W  = OFS_W - 2;

    logic [VN_W-1:0]  vec_num;
    logic [OFS_W-1:0] vec_ofs;

    // Vector number and its byte offset in the table.
    always_comb begin
        vec_num = VN_W'(VEC_FIRST) + VN_W'(trap_num);
        vec_ofs = {vec_num, 2'b00};
    end

    // Frame word and table slot address.
    always_comb begin
        fmt_word = {FMT_CODE, 2'b00, vec_ofs};
        vec_addr = vbr + {{(ADDR_W-OFS_W){1'b0}}, vec_ofs};
    end

endmodule

// File: rtl/frame_seq_fsm.sv
// Access sequencer and architectural registers (SP, PC, address register).
// One state per memory access; each state holds its request until ready,
// then updates SP and moves on. Start is sampled only in the idle state.
// Assumes mem_rdata is valid in the cycle mem_ready is high.
module frame_seq_fsm
    import frame_seq_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              TRAP_W   = 4,
    parameter logic [ADDR_W-1:0] SP_RESET = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic [ADDR_W-1:0] vbr,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] areg_in,
    input  logic [SR_W-1:0]   fmt_word,
    input  logic [ADDR_W-1:0] vec_addr,
    output logic [TRAP_W-1:0] trap_q,
    output logic [ADDR_W-1:0] vbr_q,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_long,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [ADDR_W-1:0] areg_out,
    output logic              s_bit,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LONG_B = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] WORD_B = ADDR_W'(2);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] sp_q, pc_q, npc_q, areg_q;
    logic [SR_W-1:0]   sr_q;
    logic              done_q;
    logic              hs;

    // Memory request for the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_long  = 1'b1;
        mem_addr  = sp_q;
        mem_wdata = '0;
        case (state_q)
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - LONG_B;
                mem_wdata = npc_q;
            end
            ST_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_long  = 1'b0;
                mem_addr  = sp_q - WORD_B;
                mem_wdata = {{(ADDR_W-SR_W){1'b0}}, sr_q};
            end
            ST_PUSH_FMT: begin
                mem_we    = 1'b1;
                mem_long  = 1'b0;
                mem_addr  = sp_q - WORD_B;
                mem_wdata = {{(ADDR_W-SR_W){1'b0}}, fmt_word};
            end
            ST_FETCH_VEC: mem_addr = vec_addr;
            ST_POP_PC:    mem_addr = sp_q;
            ST_PUSH_EA: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - LONG_B;
                mem_wdata = areg_q;
            end
            ST_POP_AREG:  mem_addr = sp_q;
            default:      mem_req  = 1'b0;
        endcase
    end

    assign hs = mem_req & mem_ready;

    // State, stack pointer and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= SP_RESET;
            pc_q    <= '0;
            npc_q   <= '0;
            areg_q  <= '0;
            sr_q    <= '0;
            trap_q  <= '0;
            vbr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        trap_q <= trap_num;
                        vbr_q  <= vbr;
                        npc_q  <= next_pc;
                        pc_q   <= next_pc;
                        areg_q <= areg_in;
                        sr_q   <= sr_in;
                        case (seq_op_e'(op))
                            OP_TRAP: begin
                                sr_q[SR_SUPER_BIT] <= 1'b1;
                                state_q <= ST_PUSH_PC;
                            end
                            OP_RTS:  state_q <= ST_POP_PC;
                            OP_PEA:  state_q <= ST_PUSH_EA;
                            default: begin
                                sp_q    <= areg_in;
                                state_q <= ST_POP_AREG;
                            end
                        endcase
                    end
                end
                ST_PUSH_PC: if (hs) begin
                    sp_q    <= sp_q - LONG_B;
                    state_q <= ST_PUSH_SR;
                end
                ST_PUSH_SR: if (hs) begin
                    sp_q    <= sp_q - WORD_B;
                    state_q <= ST_PUSH_FMT;
                end
                ST_PUSH_FMT: if (hs) begin
                    sp_q    <= sp_q - WORD_B;
                    state_q <= ST_FETCH_VEC;
                end
                ST_FETCH_VEC: if (hs) begin
                    pc_q    <= mem_rdata;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_POP_PC: if (hs) begin
                    pc_q    <= mem_rdata;
                    sp_q    <= sp_q + LONG_B;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_PUSH_EA: if (hs) begin
                    sp_q    <= sp_q - LONG_B;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_POP_AREG: if (hs) begin
                    areg_q  <= mem_rdata;
                    sp_q    <= sp_q + LONG_B;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Architectural outputs.
    always_comb begin
        pc_out   = pc_q;
        sp_out   = sp_q;
        areg_out = areg_q;
        s_bit    = sr_q[SR_SUPER_BIT];
        busy     = (state_q != ST_IDLE);
        done     = done_q;
    end

endmodule

// File: rtl/frame_seq.sv
// Top of the stack frame sequencer: wires the access FSM to the
// format/vector address generator. Assumes a memory that answers each
// request with a ready pulse, possibly after wait cycles.
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                TRAP_W   = 4,
    parameter logic [3:0]        FMT_CODE = 4'h4,
    parameter logic [ADDR_W-1:0] SP_RESET = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic [ADDR_W-1:0] vbr,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] areg_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_long,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [ADDR_W-1:0] areg_out,
    output logic              s_bit,
    output logic              busy,
    output logic              done
);
    logic [TRAP_W-1:0] trap_q;
    logic [ADDR_W-1:0] vbr_q;
    logic [SR_W-1:0]   fmt_word;
    logic [ADDR_W-1:0] vec_addr;

    frame_seq_fmt #(
        .ADDR_W(ADDR_W), .TRAP_W(TRAP_W), .FMT_CODE(FMT_CODE)
    ) u_fmt (
        .trap_num(trap_q), .vbr(vbr_q),
        .fmt_word(fmt_word), .vec_addr(vec_addr)
    );

    frame_seq_fsm #(
        .ADDR_W(ADDR_W), .TRAP_W(TRAP_W), .SP_RESET(SP_RESET)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .trap_num(trap_num), .vbr(vbr), .next_pc(next_pc),
        .sr_in(sr_in), .areg_in(areg_in),
        .fmt_word(fmt_word), .vec_addr(vec_addr),
        .trap_q(trap_q), .vbr_q(vbr_q),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_long(mem_long),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_out(pc_out), .sp_out(sp_out), .areg_out(areg_out),
        .s_bit(s_bit), .busy(busy), .done(done)
    );

endmodule

// File: rtl/frame_seq_chk.sv
// Protocol checker for frame_seq, bound to every instance.
// Assumes synchronous active-low reset; all checks are off while in reset.
module frame_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic              mem_long,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] sp_out,
    input logic              busy,
    input logic              done
);
    // R9: completion pulse lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the sequencer is idle when it reports completion.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: requests only come from an active operation.
    assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8: a waiting request holds all of its fields.
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
            $stable(mem_wdata) && $stable(mem_we) && $stable(mem_long)));

    // R10: SP moves only on a handshake or an accepted start.
    assert_sp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_req && mem_ready) && !(start && !busy)) |=> $stable(sp_out));

endmodule

bind frame_seq frame_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .busy(busy), .done(done)
);

// File: tb/frame_seq_bench.sv
// Self-checking bench: byte-addressed big-endian memory model with
// programmable wait states, an access log, a vector table walk and
// directed tests for reset, busy-ignore and the done pulse.
module frame_seq_bench;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  trap;
        logic [31:0] areg;
        logic [15:0] sr;
        logic [31:0] npc;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{op:2'd0, trap:4'd0,  areg:32'h0,         sr:16'h0700, npc:32'h0000_1234, lat:4'd0},
        '{op:2'd0, trap:4'd15, areg:32'h0,         sr:16'h0015, npc:32'h00AB_CDEF, lat:4'd2},
        '{op:2'd1, trap:4'd0,  areg:32'h0,         sr:16'h2000, npc:32'h0000_0100, lat:4'd1},
        '{op:2'd2, trap:4'd0,  areg:32'hDEAD_BEEF, sr:16'h0000, npc:32'h0000_0200, lat:4'd3},
        '{op:2'd3, trap:4'd0,  areg:32'h0000_0500, sr:16'h2004, npc:32'h0000_0300, lat:4'd1},
        '{op:2'd0, trap:4'd7,  areg:32'h0,         sr:16'h0000, npc:32'h0000_0404, lat:4'd0}
    };
    localparam logic [31:0] VBR = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [3:0]  trap_num = 4'd0;
    logic [31:0] vbr = VBR;
    logic [31:0] next_pc = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] areg_in = '0;
    logic        mem_req, mem_we, mem_long;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [31:0] pc_out, sp_out, areg_out;
    logic        s_bit, busy, done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0]  mem [0:4095];
    logic [31:0] log_addr  [0:63];
    logic [31:0] log_data  [0:63];
    logic        log_we    [0:63];
    logic        log_long  [0:63];
    int          log_n = 0;
    int          cnt   = 0;
    int          lat   = 0;

    logic [31:0] exp_addr [0:3];
    logic [31:0] exp_data [0:3];
    logic        exp_we   [0:3];
    logic        exp_long [0:3];
    int          exp_n;
    logic [31:0] exp_sp = 32'h0000_0400;

    always #10 clk = ~clk;

    frame_seq u_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .trap_num(trap_num), .vbr(vbr), .next_pc(next_pc),
        .sr_in(sr_in), .areg_in(areg_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_long(mem_long),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_out(pc_out), .sp_out(sp_out), .areg_out(areg_out),
        .s_bit(s_bit), .busy(busy), .done(done)
    );

    function automatic logic [31:0] rd32(logic [31:0] a);
        logic [11:0] b;
        b = a[11:0];
        return {mem[b], mem[b + 12'd1], mem[b + 12'd2], mem[b + 12'd3]};
    endfunction

    assign mem_rdata = rd32(mem_addr);

    // Memory model: preload in reset, wait states, writes and access log.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
            for (int i = 0; i < 16; i++) begin
                logic [31:0] v;
                logic [11:0] b;
                v = 32'hF000_0010 | (32'(i) << 8);
                b = 12'h880 + 12'(4 * i);
                {mem[b], mem[b + 12'd1], mem[b + 12'd2], mem[b + 12'd3]} = v;
            end
            {mem[12'h500], mem[12'h501], mem[12'h502], mem[12'h503]} = 32'h1357_2468;
            cnt = 0;
            mem_ready <= 1'b0;
        end else if (mem_req && mem_ready) begin
            if (log_n < 64) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_we[log_n]   = mem_we;
                log_long[log_n] = mem_long;
                log_n = log_n + 1;
            end
            if (mem_we) begin
                if (mem_long)
                    {mem[mem_addr[11:0]], mem[mem_addr[11:0] + 12'd1],
                     mem[mem_addr[11:0] + 12'd2], mem[mem_addr[11:0] + 12'd3]} = mem_wdata;
                else
                    {mem[mem_addr[11:0]], mem[mem_addr[11:0] + 12'd1]} = mem_wdata[15:0];
            end
            cnt = 0;
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            if (cnt >= lat) mem_ready <= 1'b1;
            else cnt = cnt + 1;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(logic [1:0] o, logic [3:0] t, logic [31:0] a,
                          logic [15:0] s, logic [31:0] p);
        op = o; trap_num = t; areg_in = a; sr_in = s; next_pc = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        ok = done;
        check("R9 done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic check_log(int base);
        check("R8 access count", 32'(log_n - base), 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            check("R8 access addr", log_addr[base + i], exp_addr[i]);
            check("R8 access we", {31'd0, log_we[base + i]}, {31'd0, exp_we[i]});
            check("R8 access size", {31'd0, log_long[base + i]}, {31'd0, exp_long[i]});
            if (exp_we[i]) check("R2 R3 R6 write data", log_data[base + i], exp_data[i]);
        end
    endtask

    // Builds the expected access list and results for a trap.
    task automatic expect_trap(logic [3:0] t, logic [15:0] s, logic [31:0] p,
                               output logic [31:0] pc_e);
        logic [31:0] slot;
        slot = VBR + 32'h80 + 32'(4 * t);
        exp_n = 4;
        exp_addr[0] = exp_sp - 4; exp_we[0] = 1; exp_long[0] = 1; exp_data[0] = p;
        exp_addr[1] = exp_sp - 6; exp_we[1] = 1; exp_long[1] = 0; exp_data[1] = {16'd0, s | 16'h2000};
        exp_addr[2] = exp_sp - 8; exp_we[2] = 1; exp_long[2] = 0;
        exp_data[2] = {16'd0, 16'h4000 | 16'((32 + t) * 4)};
        exp_addr[3] = slot; exp_we[3] = 0; exp_long[3] = 1; exp_data[3] = '0;
        pc_e = rd32(slot);
        exp_sp = exp_sp - 8;
    endtask

    task automatic run_vec(vec_t v);
        int base;
        bit ok;
        logic [31:0] pc_e, areg_e;
        logic s_e;
        areg_e = 32'hx;
        pc_e = v.npc;
        s_e = v.sr[13];
        lat = int'(v.lat);
        case (v.op)
            2'd0: begin expect_trap(v.trap, v.sr, v.npc, pc_e); s_e = 1'b1; end
            2'd1: begin
                exp_n = 1;
                exp_addr[0] = exp_sp; exp_we[0] = 0; exp_long[0] = 1; exp_data[0] = '0;
                pc_e = rd32(exp_sp);
                exp_sp = exp_sp + 4;
            end
            2'd2: begin
                exp_n = 1;
                exp_addr[0] = exp_sp - 4; exp_we[0] = 1; exp_long[0] = 1; exp_data[0] = v.areg;
                exp_sp = exp_sp - 4;
            end
            default: begin
                exp_n = 1;
                exp_addr[0] = v.areg; exp_we[0] = 0; exp_long[0] = 1; exp_data[0] = '0;
                areg_e = rd32(v.areg);
                exp_sp = v.areg + 4;
            end
        endcase
        base = log_n;
        launch(v.op, v.trap, v.areg, v.sr, v.npc);
        wait_done(ok);
        check("R9 busy low at done", {31'd0, busy}, 32'd0);
        check("R2 R5 R6 R7 final sp", sp_out, exp_sp);
        check("R4 R5 R11 final pc", pc_out, pc_e);
        check("R4 R11 s_bit", {31'd0, s_bit}, {31'd0, s_e});
        if (v.op == 2'd3) check("R7 areg reload", areg_out, areg_e);
        check_log(base);
        @(negedge clk);
        check("R9 done one cycle", {31'd0, done}, 32'd0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 sp reset", sp_out, 32'h0000_0400);
        check("R1 pc reset", pc_out, 32'h0);
        check("R1 areg reset", areg_out, 32'h0);
        check("R1 s_bit reset", {31'd0, s_bit}, 32'd0);
        check("R1 busy/done/req reset", {29'd0, busy, done, mem_req}, 32'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: start during a trap is ignored
        begin
            int base;
            bit ok;
            logic [31:0] pc_e;
            lat = 4;
            expect_trap(4'd1, 16'h0100, 32'h0000_0ABC, pc_e);
            base = log_n;
            launch(2'd0, 4'd1, 32'h0, 16'h0100, 32'h0000_0ABC);
            repeat (3) @(negedge clk);
            check("R10 busy during trap", {31'd0, busy}, 32'd1);
            launch(2'd2, 4'd3, 32'h5555_AAAA, 16'h0000, 32'h0000_0999);
            wait_done(ok);
            check("R10 sp after ignored start", sp_out, exp_sp);
            check("R10 pc after ignored start", pc_out, pc_e);
            check_log(base);
            repeat (6) @(negedge clk);
            check("R10 no extra access", 32'(log_n - base), 32'd4);
            check("R10 idle after", {30'd0, busy, mem_req}, 32'd0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule